// File: doc/BRIEF.md
# Two-Port Key Relay Bridge

This block hands a session key and a message length from one microcontroller to another. Each controller is an independent SPI master with its own serial clock and chip select, and the block is an SPI slave on both sides. All of its logic runs on the fabric clock. The upstream controller (port A) writes a 136-bit frame: the 128-bit key, then the 8-bit total message length. The block stores that frame. The downstream controller (port B) can then read it back at any time through its own transaction.

Both ports use SPI mode 0. The master changes data while the serial clock is low, and the slave samples on the rising edge. Bits travel most significant first. The key's MSB comes first, and the length byte's LSB is the last of the 136 bits. Every serial clock, chip select and data input passes through a two-stage synchroniser before edge detection, so the master's serial clock must be several fabric clocks slower than the fabric clock. The block keeps the last complete frame and a sticky valid flag.

Top module: `key_relay_bridge`

## Requirements
- R1: A port A transaction that delivers exactly 136 bits is stored. Bit 0 of the transaction is key bit 127, bit 127 is key bit 0, and bits 128 to 135 are the length, MSB first. A later port B read returns the same 136 bits in the same order.
- R2: A port A transaction that ends with any bit count other than 136 is discarded. The previously stored frame is left unchanged.
- R3: `frame_valid` is 0 after reset. It becomes 1 after the first accepted frame and never returns to 0 until reset.
- R4: While `frame_valid` is 0, a port B read returns all zeros.
- R5: `b_miso` is 0 whenever `b_cs_n` has been high for a few fabric clocks.
- R6: A port B read returns the frame that was stored when its chip select fell. A port A frame accepted during that read changes only later reads.
- R7: Port B reads do not consume the frame. Repeated reads return the same value.
- R8: Port B clock edges beyond bit 136 of one read shift out zeros.
- R9: Directly after reset, `b_miso` and `frame_valid` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_sck | input | 1 | Port A serial clock from upstream master |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_mosi | input | 1 | Port A serial data into the block |
| b_sck | input | 1 | Port B serial clock from downstream master |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_miso | output | 1 | Port B serial data out of the block, low when deselected |
| frame_valid | output | 1 | A complete frame has been stored since reset |

## Verification
The assertions check four properties on every cycle:
- `frame_valid` never drops.
- `frame_valid` only rises after an accepted frame, and only with port A deselected.
- The stored frame changes only on acceptance.
- `b_miso` stays low while port B is idle or no frame is valid.

The bench scenarios cover everything that needs a whole transaction to see. These are the 136-bit count rule with short and long frames, the bit order, the zero tail past bit 136, repeated reads, and the snapshot taken at chip-select assertion while a new frame lands in parallel.

// File: rtl/krb_pkg.sv
package krb_pkg;
  localparam int DEF_KEY_W  = 128;
  localparam int DEF_LEN_W  = 8;
  localparam int DEF_STAGES = 2;

  // Synchronised view of one SPI slave port
  typedef struct packed {
    logic sck_rise;
    logic sck_fall;
    logic sel;        // chip select active
    logic sel_start;  // chip select just asserted
    logic sel_end;    // chip select just released
    logic dat;        // synchronised data input
  } port_evt_t;
endpackage

// File: rtl/krb_port_sync.sv
module krb_port_sync
  import krb_pkg::*;
#(
  parameter int STAGES = DEF_STAGES
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sck_i,
  input  logic      cs_n_i,
  input  logic      dat_i,
  output port_evt_t evt_o
);
  localparam int NL = 3;                 // {sck, cs_n, dat}
  localparam logic [NL-1:0] IDLE = 3'b010;

  logic [STAGES-1:0][NL-1:0] chain_q;
  logic [NL-1:0]             prev_q;
  logic [NL-1:0]             sync_w;

  genvar st;
  generate
    for (st = 0; st < STAGES; st++) begin : g_stage
      if (st == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[st] <= IDLE;
          else        chain_q[st] <= {sck_i, cs_n_i, dat_i};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[st] <= IDLE;
          else        chain_q[st] <= chain_q[st-1];
        end
      end
    end
  endgenerate

  assign sync_w = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= sync_w;
  end

  always_comb begin
    evt_o.sck_rise  = sync_w[2] & ~prev_q[2];
    evt_o.sck_fall  = ~sync_w[2] & prev_q[2];
    evt_o.sel       = ~sync_w[1];
    evt_o.sel_start = ~sync_w[1] & prev_q[1];
    evt_o.sel_end   = sync_w[1] & ~prev_q[1];
    evt_o.dat       = sync_w[0];
  end

  logic unused_prev;
  assign unused_prev = prev_q[0];
endmodule

// File: rtl/krb_rx.sv
module krb_rx
  import krb_pkg::*;
#(
  parameter int FRAME_W = DEF_KEY_W + DEF_LEN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  port_evt_t          evt_i,
  output logic               ok_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int CNT_MAX = FRAME_W + 1;

  logic [FRAME_W-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               shift_en, cnt_en;

  always_comb begin
    shift_en = evt_i.sel & evt_i.sck_rise;
    cnt_en   = evt_i.sel_start | shift_en;
    shift_d  = {shift_q[FRAME_W-2:0], evt_i.dat};
    if (evt_i.sel_start)                   cnt_d = '0;
    else if (cnt_q == CNT_W'(CNT_MAX))     cnt_d = cnt_q;
    else                                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (shift_en) shift_q <= shift_d;
      if (cnt_en)   cnt_q   <= cnt_d;
    end
  end

  assign ok_o    = evt_i.sel_end & (cnt_q == CNT_W'(FRAME_W));
  assign frame_o = shift_q;

  logic unused_evt;
  assign unused_evt = evt_i.sck_fall;
endmodule

// File: rtl/krb_tx.sv
module krb_tx
  import krb_pkg::*;
#(
  parameter int FRAME_W = DEF_KEY_W + DEF_LEN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  port_evt_t          evt_i,
  input  logic [FRAME_W-1:0] load_i,
  output logic               miso_o
);
  logic [FRAME_W-1:0] shift_q, shift_d;
  logic               shift_en;

  always_comb begin
    shift_en = evt_i.sel_start | (evt_i.sel & evt_i.sck_fall);
    if (evt_i.sel_start) shift_d = load_i;
    else                 shift_d = {shift_q[FRAME_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shift_q <= '0;
    else if (shift_en) shift_q <= shift_d;
  end

  assign miso_o = evt_i.sel & shift_q[FRAME_W-1];

  logic unused_evt;
  assign unused_evt = ^{evt_i.sck_rise, evt_i.sel_end, evt_i.dat};
endmodule

// File: rtl/key_relay_bridge.sv
module key_relay_bridge
  import krb_pkg::*;
#(
  parameter int KEY_W       = DEF_KEY_W,
  parameter int LEN_W       = DEF_LEN_W,
  parameter int SYNC_STAGES = DEF_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_sck,
  input  logic a_cs_n,
  input  logic a_mosi,
  input  logic b_sck,
  input  logic b_cs_n,
  output logic b_miso,
  output logic frame_valid
);
  localparam int FRAME_W = KEY_W + LEN_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  port_evt_t a_evt, b_evt;

  krb_port_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk), .rst_n(rst_int_n),
    .sck_i(a_sck), .cs_n_i(a_cs_n), .dat_i(a_mosi), .evt_o(a_evt)
  );

  krb_port_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk), .rst_n(rst_int_n),
    .sck_i(b_sck), .cs_n_i(b_cs_n), .dat_i(1'b0), .evt_o(b_evt)
  );

  logic               rx_ok;
  logic [FRAME_W-1:0] rx_frame;

  krb_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk(clk), .rst_n(rst_int_n), .evt_i(a_evt),
    .ok_o(rx_ok), .frame_o(rx_frame)
  );

  // store-and-forward holding register
  logic [FRAME_W-1:0] store_q, store_d, tx_load;
  logic               valid_q, valid_d;

  always_comb begin
    store_d = rx_frame;
    valid_d = 1'b1;
    tx_load = valid_q ? store_q : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      store_q <= '0;
      valid_q <= 1'b0;
    end else if (rx_ok) begin
      store_q <= store_d;
      valid_q <= valid_d;
    end
  end

  krb_tx #(.FRAME_W(FRAME_W)) u_tx (
    .clk(clk), .rst_n(rst_int_n), .evt_i(b_evt),
    .load_i(tx_load), .miso_o(b_miso)
  );

  assign frame_valid = valid_q;
endmodule

// File: rtl/krb_checker.sv
module krb_checker #(
  parameter int FRAME_W = 136
) (
  input logic               clk,
  input logic               rst_n,
  input logic               a_cs_n,
  input logic               b_cs_n,
  input logic               b_miso,
  input logic               frame_valid,
  input logic               rx_ok,
  input logic [FRAME_W-1:0] store_q
);
  a_r3_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(frame_valid));

  a_r3_valid_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_valid) |-> $past(rx_ok));

  a_r1_accept_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_valid) |-> $past(a_cs_n, 3));

  a_r2_store_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ok |=> $stable(store_q));

  a_r4_zero_until_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> !b_miso);

  a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (b_cs_n && $past(b_cs_n) && $past(b_cs_n, 2) && $past(b_cs_n, 3)) |-> !b_miso);
endmodule

bind key_relay_bridge krb_checker #(.FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_cs_n(a_cs_n), .b_cs_n(b_cs_n),
  .b_miso(b_miso), .frame_valid(frame_valid), .rx_ok(rx_ok), .store_q(store_q)
);

// File: tb/key_relay_bridge_test.sv
`timescale 1ns/1ps
module key_relay_bridge_test;
  localparam int FW = 136;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_sck = 1'b0, a_cs_n = 1'b1, a_mosi = 1'b0;
  logic b_sck = 1'b0, b_cs_n = 1'b1;
  logic b_miso, frame_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  key_relay_bridge uut (
    .clk(clk), .rst_n(rst_n),
    .a_sck(a_sck), .a_cs_n(a_cs_n), .a_mosi(a_mosi),
    .b_sck(b_sck), .b_cs_n(b_cs_n), .b_miso(b_miso),
    .frame_valid(frame_valid)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req,
                       input logic [143:0] act, input logic [143:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] make_frame(input logic [127:0] key,
                                               input logic [7:0] len);
    return {key, len};
  endfunction

  function automatic logic [FW-1:0] rand_frame();
    return make_frame({$urandom, $urandom, $urandom, $urandom}, 8'($urandom));
  endfunction

  // port A master: v[143] goes out first, n bits in total
  task automatic a_send(input logic [143:0] v, input int n, input int h);
    a_cs_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      a_mosi = v[143-i];
      tick(h);
      a_sck = 1'b1;
      tick(h);
      a_sck = 1'b0;
    end
    tick(h);
    a_cs_n = 1'b1;
    a_mosi = 1'b0;
    tick(h + 4);
  endtask

  // port B master: samples MISO just before each rising edge
  task automatic b_read(input int n, input int h, output logic [143:0] got);
    got = '0;
    b_cs_n = 1'b0;
    tick(h);
    for (int i = 0; i < n; i++) begin
      got = {got[142:0], b_miso};
      b_sck = 1'b1;
      tick(h);
      b_sck = 1'b0;
      tick(h);
    end
    b_cs_n = 1'b1;
    tick(h + 4);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0]  last, f;
    logic [143:0]   got;
    void'($urandom(32'h1A2B3C4D));

    tick(4);
    rst_n = 1'b1;
    tick(8);
    // R9 reset state
    check(b_miso == 1'b0, "R9 miso after reset", 144'(b_miso), 144'(0));
    check(frame_valid == 1'b0, "R9/R3 valid after reset", 144'(frame_valid), 144'(0));

    // R4 read before any frame
    b_read(FW, 5, got);
    check(got[FW-1:0] == '0, "R4 read with no frame", got, 144'(0));

    // R2 short frame ignored while empty
    f = rand_frame();
    a_send({f, 8'h00}, 135, 4);
    check(frame_valid == 1'b0, "R2 short frame sets no valid", 144'(frame_valid), 144'(0));
    b_read(FW, 4, got);
    check(got[FW-1:0] == '0, "R4 read after short frame", got, 144'(0));

    // R1 first good frame: directed pattern
    last = make_frame(128'h8000_0000_0000_0000_0000_0000_0000_0001, 8'hA5);
    a_send({last, 8'h00}, FW, 5);
    check(frame_valid == 1'b1, "R3 valid after good frame", 144'(frame_valid), 144'(1));
    b_read(FW, 6, got);
    check(got[FW-1:0] == last, "R1 key then length MSB first", got, 144'(last));
    b_read(FW, 4, got);
    check(got[FW-1:0] == last, "R7 repeat read", got, 144'(last));
    check(b_miso == 1'b0, "R5 miso idle low", 144'(b_miso), 144'(0));

    // mixed random frames
    for (int it = 0; it < 10; it++) begin
      int kind, n, ha, hb;
      kind = int'($urandom % 4);
      ha = 4 + int'($urandom % 4);
      hb = 4 + int'($urandom % 4);
      f = rand_frame();
      if (kind == 0)      n = 1 + int'($urandom % 135);
      else if (kind == 1) n = 137 + int'($urandom % 8);
      else                n = FW;
      a_send({f, 8'($urandom)}, n, ha);
      if (n == FW) last = f;
      b_read(FW, hb, got);
      if (n == FW)
        check(got[FW-1:0] == last, "R1 random frame relayed", got, 144'(last));
      else
        check(got[FW-1:0] == last, "R2 bad length frame discarded", got, 144'(last));
      check(frame_valid == 1'b1, "R3 valid stays set", 144'(frame_valid), 144'(1));
      check(b_miso == 1'b0, "R5 miso idle low", 144'(b_miso), 144'(0));
    end

    // R8 overlong read gives zero tail
    b_read(144, 4, got);
    check(got == {last, 8'h00}, "R8 zeros past bit 136", got, {last, 8'h00});

    // R6 new frame lands during a read
    f = rand_frame();
    fork
      b_read(FW, 6, got);
      begin
        tick(20);
        a_send({f, 8'h00}, FW, 4);
      end
    join
    check(got[FW-1:0] == last, "R6 read keeps snapshot", got, 144'(last));
    last = f;
    b_read(FW, 5, got);
    check(got[FW-1:0] == last, "R6 next read sees new frame", got, 144'(last));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule